// File: doc/BRIEF.md
# Scoreboard Hazard Tracking Controller

This block is the central scheduler for a small out-of-order execution core. Issue requests arrive in program order, one per cycle. Each request carries an operation class, an opcode, a destination register and two source registers. The block assigns each accepted request to a free functional unit of that class. It then decides when the unit may fetch its operands from the register file and when its result may be written back. A status record for every unit and a producer tag for every architectural register track all instructions in flight.

The functional-unit datapaths sit outside the block. A unit is told to start by a read grant, which comes with its opcode and both operand values. When the unit finishes, it returns a one-cycle done pulse together with its result. The register file lives inside the block. It has one operand-read grant and one write-back grant per cycle.

An operand read waits only until the producers of both sources have written back, which removes read-after-write hazards. A write-back waits only until every unit that still needs the old value of the destination has read it, which removes write-after-read hazards. A request whose destination already has a pending writer is not accepted, and neither is a request whose class has no free unit. Both cases are handled only by the stall output.

Top module: `sb_sched`

## Requirements
- R1: With `iss_valid` high, `iss_stall` is high whenever every unit of the requested class is busy, even if units of the other class are free. A request for a class with a free unit is accepted. Class c owns units 2c and 2c+1.
- R2: With `iss_valid` high, `iss_stall` is high while the requested destination register has a pending writer, even if a unit of the class is free.
- R3: An accepted request goes to the lowest-indexed free unit of its class. `iss_tag` reports that unit's index plus one, and 0 means no unit is free.
- R4: A unit is not granted an operand read while either of its sources still awaits an in-flight producer. Once it is granted, `rd_a`/`rd_b` hold the register-file contents of source 1/source 2, including any value written back before the grant.
- R5: `rd_grant` is one-hot or zero. Bit i stands for unit i, and among the units ready to read, the lowest index wins. Each unit is granted exactly once per instruction.
- R6: A unit is granted write-back only after it has been granted its read and has then received a `fu_done` pulse. A pulse that arrives before the read is ignored.
- R7: A finished unit is not granted write-back while another unit that is still waiting to read has a source equal to the finished unit's destination, with that source's operand not yet fetched.
- R8: `wb_grant` is one-hot or zero, and the lowest-indexed eligible unit wins. `wb_reg`/`wb_data` give the destination register and the result.
- R9: Write-back stores the result into the register file and wakes every waiting consumer of that unit. It also clears the destination's pending writer and frees the unit for reissue.
- R10: After reset, no unit is busy, no register has a pending writer, every register reads as zero and both grant vectors are zero.
- R11: An instruction whose source equals its own destination reads the value the register held before that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request present |
| iss_cls | input | 1 | Operation class of the request |
| iss_op | input | 4 | Opcode passed through to the unit |
| iss_dst | input | 3 | Destination register |
| iss_src1 | input | 3 | First source register |
| iss_src2 | input | 3 | Second source register |
| iss_stall | output | 1 | Request cannot be accepted this cycle |
| iss_tag | output | 3 | Unit index + 1 that would take the request, 0 if none |
| rd_grant | output | 4 | One-hot operand-read grant per unit |
| rd_op | output | 4 | Opcode of the granted unit |
| rd_a | output | 32 | First operand of the granted unit |
| rd_b | output | 32 | Second operand of the granted unit |
| fu_done | input | 4 | Result-ready pulse per unit |
| fu_result | input | 128 | Results, unit i in bits 32i+31..32i |
| wb_grant | output | 4 | One-hot write-back grant per unit |
| wb_reg | output | 3 | Register being written |
| wb_data | output | 32 | Value being written |

## Verification
Corrupted state shows up at the ports within a few cycles. A lost wake-up leaves `rd_grant` at zero forever for the consumer. A missed read-clear shows up as a second grant to the same unit on the very next cycle. A wrong producer tag or a stale register entry surfaces at the consumer's read grant as a wrong `rd_a`/`rd_b` value, or it leaves `iss_stall` stuck high for the next writer of that register. A broken write-after-read check shows up as `wb_grant` firing in the same cycle as, or before, the read grant of the unit that still needed the old value. Each scenario therefore checks the grant vectors and operand values cycle by cycle, against values the bench tracks as it writes each register.

// File: rtl/sb_sched.sv
module sb_sched #(
  parameter int NCLS    = 2,
  parameter int PER_CLS = 2,
  parameter int NREG    = 8,
  parameter int W       = 32,
  parameter int OPW     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  iss_valid,
  input  logic [((NCLS>1)?$clog2(NCLS):1)-1:0] iss_cls,
  input  logic [OPW-1:0]        iss_op,
  input  logic [$clog2(NREG)-1:0] iss_dst,
  input  logic [$clog2(NREG)-1:0] iss_src1,
  input  logic [$clog2(NREG)-1:0] iss_src2,
  output logic                  iss_stall,
  output logic [$clog2(NCLS*PER_CLS+1)-1:0] iss_tag,
  output logic [NCLS*PER_CLS-1:0] rd_grant,
  output logic [OPW-1:0]        rd_op,
  output logic [W-1:0]          rd_a,
  output logic [W-1:0]          rd_b,
  input  logic [NCLS*PER_CLS-1:0] fu_done,
  input  logic [NCLS*PER_CLS*W-1:0] fu_result,
  output logic [NCLS*PER_CLS-1:0] wb_grant,
  output logic [$clog2(NREG)-1:0] wb_reg,
  output logic [W-1:0]          wb_data
);
  localparam int NFU = NCLS * PER_CLS;
  localparam int TW  = $clog2(NFU + 1);
  localparam int RW  = $clog2(NREG);
  localparam int IW  = (NFU > 1) ? $clog2(NFU) : 1;
  localparam int CW  = (NCLS > 1) ? $clog2(NCLS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_EX, S_WB} st_t;

  st_t            st    [NFU];
  logic [OPW-1:0] op_q  [NFU];
  logic [RW-1:0]  fi    [NFU];
  logic [RW-1:0]  fj    [NFU];
  logic [RW-1:0]  fk    [NFU];
  logic [TW-1:0]  qj    [NFU];
  logic [TW-1:0]  qk    [NFU];
  logic           rj    [NFU];
  logic           rk    [NFU];
  logic [W-1:0]   res   [NFU];
  logic [TW-1:0]  rstat [NREG];
  logic [W-1:0]   rf    [NREG];

  logic          rd_any, wb_any, free_any, do_iss;
  logic [IW-1:0] rd_sel, wb_sel, free_sel;
  logic [TW-1:0] wb_tag, tj, tk;
  logic [NFU-1:0] war_ok;

  always_comb begin
    rd_any = 1'b0; rd_sel = '0;
    wb_any = 1'b0; wb_sel = '0;
    free_any = 1'b0; free_sel = '0;
    for (int i = 0; i < NFU; i++) begin
      war_ok[i] = 1'b1;
      for (int f = 0; f < NFU; f++)
        if (f != i && st[f] == S_RD &&
            ((fj[f] == fi[i] && rj[f]) || (fk[f] == fi[i] && rk[f])))
          war_ok[i] = 1'b0;
    end
    for (int i = NFU - 1; i >= 0; i--) begin
      if (st[i] == S_RD && rj[i] && rk[i]) begin rd_any = 1'b1; rd_sel = IW'(i); end
      if (st[i] == S_WB && war_ok[i])       begin wb_any = 1'b1; wb_sel = IW'(i); end
      if (st[i] == S_IDLE && CW'(i / PER_CLS) == iss_cls) begin
        free_any = 1'b1; free_sel = IW'(i);
      end
    end
  end

  assign wb_tag    = TW'(wb_sel) + TW'(1);
  assign iss_tag   = free_any ? TW'(free_sel) + TW'(1) : '0;
  assign iss_stall = iss_valid && (!free_any || rstat[iss_dst] != '0);
  assign do_iss    = iss_valid && !iss_stall;
  assign tj        = (wb_any && rstat[iss_src1] == wb_tag) ? '0 : rstat[iss_src1];
  assign tk        = (wb_any && rstat[iss_src2] == wb_tag) ? '0 : rstat[iss_src2];

  assign rd_grant = rd_any ? (NFU'(1) << rd_sel) : '0;
  assign rd_op    = op_q[rd_sel];
  assign rd_a     = rf[fj[rd_sel]];
  assign rd_b     = rf[fk[rd_sel]];
  assign wb_grant = wb_any ? (NFU'(1) << wb_sel) : '0;
  assign wb_reg   = fi[wb_sel];
  assign wb_data  = res[wb_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NFU; i++) begin
        st[i] <= S_IDLE; op_q[i] <= '0; fi[i] <= '0; fj[i] <= '0; fk[i] <= '0;
        qj[i] <= '0; qk[i] <= '0; rj[i] <= 1'b0; rk[i] <= 1'b0; res[i] <= '0;
      end
      for (int r = 0; r < NREG; r++) begin
        rstat[r] <= '0; rf[r] <= '0;
      end
    end else begin
      for (int i = 0; i < NFU; i++) begin
        if (wb_any && st[i] == S_RD && qj[i] == wb_tag) begin rj[i] <= 1'b1; qj[i] <= '0; end
        if (wb_any && st[i] == S_RD && qk[i] == wb_tag) begin rk[i] <= 1'b1; qk[i] <= '0; end
        if (rd_any && rd_sel == IW'(i)) begin
          rj[i] <= 1'b0; rk[i] <= 1'b0; st[i] <= S_EX;
        end
        if (st[i] == S_EX && fu_done[i]) begin
          res[i] <= fu_result[i*W +: W]; st[i] <= S_WB;
        end
        if (wb_any && wb_sel == IW'(i)) st[i] <= S_IDLE;
        if (do_iss && free_sel == IW'(i)) begin
          st[i] <= S_RD; op_q[i] <= iss_op;
          fi[i] <= iss_dst; fj[i] <= iss_src1; fk[i] <= iss_src2;
          qj[i] <= tj; qk[i] <= tk;
          rj[i] <= (tj == '0); rk[i] <= (tk == '0);
        end
      end
      if (wb_any) begin
        rstat[fi[wb_sel]] <= '0;
        rf[fi[wb_sel]]    <= res[wb_sel];
      end
      if (do_iss) rstat[iss_dst] <= iss_tag;
    end
  end

  p_rd_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rd_grant));
  p_wb_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wb_grant));
  p_iss_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_stall) |=> (rstat[$past(iss_dst)] == $past(iss_tag)));
  p_iss_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_stall) |-> (iss_tag != '0));
  p_read_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> (st[$past(rd_sel)] == S_EX));
  p_no_war_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && wb_any) |-> (fj[rd_sel] != wb_reg && fk[rd_sel] != wb_reg));
  p_wb_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_any |=> (rstat[$past(wb_reg)] == '0 && st[$past(wb_sel)] == S_IDLE));
endmodule

// File: tb/sb_sched_tb_top.sv
`timescale 1ns/1ps
module sb_sched_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, iss_valid, iss_cls, iss_stall;
  logic [3:0]  iss_op, rd_grant, fu_done, wb_grant, rd_op;
  logic [2:0]  iss_dst, iss_src1, iss_src2, iss_tag, wb_reg;
  logic [31:0] rd_a, rd_b, wb_data;
  logic [127:0] fu_result;

  sb_sched dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_cls(iss_cls), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2), .iss_stall(iss_stall),
    .iss_tag(iss_tag), .rd_grant(rd_grant), .rd_op(rd_op), .rd_a(rd_a), .rd_b(rd_b),
    .fu_done(fu_done), .fu_result(fu_result), .wb_grant(wb_grant), .wb_reg(wb_reg),
    .wb_data(wb_data));

  int checks = 0, errors = 0;
  logic [31:0] mreg [8];

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #2;
  endtask

  task automatic issue(input logic cls, input logic [3:0] op, input logic [2:0] d, s1, s2,
                       input logic [2:0] etag, input string what);
    iss_valid = 1'b1; iss_cls = cls; iss_op = op; iss_dst = d; iss_src1 = s1; iss_src2 = s2;
    #1;
    chk({what, " stall"}, 32'(iss_stall), 32'd0);
    chk({what, " tag"}, 32'(iss_tag), 32'(etag));
    step;
    iss_valid = 1'b0;
    #1;
  endtask

  task automatic done(input logic [3:0] mask, input logic [31:0] v0, v1, v2, v3);
    fu_done = mask;
    fu_result = {v3, v2, v1, v0};
    step;
    fu_done = '0;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; iss_valid = 1'b0; iss_cls = 1'b0; iss_op = '0; iss_dst = '0;
    iss_src1 = '0; iss_src2 = '0; fu_done = '0; fu_result = '0;
    for (int r = 0; r < 8; r++) mreg[r] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    // R10 reset state
    chk("R10 rd_grant", 32'(rd_grant), 0);
    chk("R10 wb_grant", 32'(wb_grant), 0);
    chk("R10 stall idle", 32'(iss_stall), 0);
    iss_valid = 1'b1; iss_cls = 1'b1; iss_dst = 3'd7; #1;
    chk("R10 R3 free class1", 32'(iss_tag), 3);
    chk("R10 no pending dst", 32'(iss_stall), 0);
    iss_valid = 1'b0; #1;

    // R9 R4 R6 sweep over every destination register
    for (int d = 1; d < 8; d++) begin
      logic [31:0] v;
      v = 32'h00A0_0000 + 32'(d) * 32'h0101_0101;
      issue(1'b0, 4'(d), 3'(d), 3'd0, 3'd0, 3'd1, "R3 sweep");
      chk("R5 sweep grant", 32'(rd_grant), 1);
      chk("R10 sweep zero reg", rd_a, 0);
      chk("R5 sweep op", 32'(rd_op), 32'(d));
      step;
      chk("R5 single read", 32'(rd_grant), 0);
      chk("R6 no wb before done", 32'(wb_grant), 0);
      done(4'b0001, v, 0, 0, 0);
      chk("R9 wb grant", 32'(wb_grant), 1);
      chk("R9 wb reg", 32'(wb_reg), 32'(d));
      chk("R9 wb data", wb_data, v);
      step;
      mreg[d] = v;
      issue(1'b0, 4'd0, 3'd0, 3'(d), 3'(d), 3'd1, "R9 readback");
      chk("R9 readback a", rd_a, v);
      chk("R9 readback b", rd_b, v);
      step;
      done(4'b0001, 0, 0, 0, 0);
      chk("R9 reg0 wb", 32'(wb_reg), 0);
      step;
    end

    // R4 RAW: consumer waits for producer
    issue(1'b0, 4'd1, 3'd3, 3'd0, 3'd0, 3'd1, "R4 producer");
    chk("R4 producer read", 32'(rd_grant), 1);
    issue(1'b1, 4'd2, 3'd5, 3'd3, 3'd0, 3'd3, "R4 consumer");
    chk("R4 consumer waits", 32'(rd_grant), 0);
    done(4'b0001, 32'hAAAA_0003, 0, 0, 0);
    chk("R4 producer wb", 32'(wb_grant), 1);
    chk("R4 consumer still waits", 32'(rd_grant), 0);
    step;
    mreg[3] = 32'hAAAA_0003;
    chk("R4 consumer grant", 32'(rd_grant), 4);
    chk("R4 forwarded value", rd_a, mreg[3]);
    chk("R4 second source", rd_b, mreg[0]);
    step;
    done(4'b0100, 0, 0, 32'h5555_0005, 0);
    chk("R9 consumer wb", 32'(wb_grant), 4);
    chk("R9 consumer wb reg", 32'(wb_reg), 5);
    step;
    mreg[5] = 32'h5555_0005;

    // R7 WAR: writer of r2 waits for a pending reader of r2
    issue(1'b0, 4'd0, 3'd6, 3'd0, 3'd0, 3'd1, "R7 P");
    chk("R7 P read", 32'(rd_grant), 1);
    issue(1'b1, 4'd0, 3'd7, 3'd2, 3'd6, 3'd3, "R7 reader");
    chk("R7 reader waits", 32'(rd_grant), 0);
    issue(1'b0, 4'd0, 3'd2, 3'd0, 3'd0, 3'd2, "R3 R7 writer");
    chk("R7 writer read", 32'(rd_grant), 2);
    step;
    done(4'b0010, 0, 32'h2222_2222, 0, 0);
    chk("R7 writer blocked", 32'(wb_grant), 0);
    done(4'b0001, 32'h6666_6666, 0, 0, 0);
    chk("R7 R8 P wb first", 32'(wb_grant), 1);
    chk("R7 P wb reg", 32'(wb_reg), 6);
    step;
    chk("R7 reader grant", 32'(rd_grant), 4);
    chk("R7 reader old r2", rd_a, mreg[2]);
    chk("R7 reader r6", rd_b, 32'h6666_6666);
    chk("R7 writer still blocked", 32'(wb_grant), 0);
    mreg[6] = 32'h6666_6666;
    step;
    chk("R7 writer released", 32'(wb_grant), 2);
    chk("R7 writer data", wb_data, 32'h2222_2222);
    step;
    mreg[2] = 32'h2222_2222;
    done(4'b0100, 0, 0, 32'h7777_7777, 0);
    chk("R9 reader wb", 32'(wb_grant), 4);
    step;
    mreg[7] = 32'h7777_7777;

    // R5 R8 priority among simultaneous requests
    issue(1'b0, 4'd0, 3'd4, 3'd0, 3'd0, 3'd1, "R5 P");
    chk("R5 P read", 32'(rd_grant), 1);
    issue(1'b0, 4'd0, 3'd1, 3'd4, 3'd0, 3'd2, "R5 X");
    issue(1'b1, 4'd0, 3'd5, 3'd4, 3'd4, 3'd3, "R5 Y");
    chk("R4 both wait", 32'(rd_grant), 0);
    done(4'b0001, 32'h4444_4444, 0, 0, 0);
    chk("R9 P wb", 32'(wb_grant), 1);
    step;
    mreg[4] = 32'h4444_4444;
    chk("R5 lowest first", 32'(rd_grant), 2);
    chk("R5 X value", rd_a, mreg[4]);
    step;
    chk("R5 next unit", 32'(rd_grant), 4);
    chk("R5 Y value", rd_b, mreg[4]);
    step;
    done(4'b0110, 0, 32'h1111_0001, 32'h5555_5555, 0);
    chk("R8 lowest wb", 32'(wb_grant), 2);
    chk("R8 lowest wb reg", 32'(wb_reg), 1);
    step;
    chk("R8 second wb", 32'(wb_grant), 4);
    chk("R8 second wb reg", 32'(wb_reg), 5);
    step;
    mreg[1] = 32'h1111_0001; mreg[5] = 32'h5555_5555;

    // R1 R2 stall conditions
    issue(1'b1, 4'd0, 3'd1, 3'd0, 3'd0, 3'd3, "R3 c1 first");
    issue(1'b1, 4'd0, 3'd2, 3'd0, 3'd0, 3'd4, "R3 c1 second");
    iss_valid = 1'b1; iss_cls = 1'b1; iss_dst = 3'd3; iss_src1 = 3'd0; iss_src2 = 3'd0; #1;
    chk("R1 class full stall", 32'(iss_stall), 1);
    chk("R3 no free tag", 32'(iss_tag), 0);
    iss_valid = 1'b0; #1;
    issue(1'b0, 4'd0, 3'd3, 3'd0, 3'd0, 3'd1, "R1 other class");
    iss_valid = 1'b1; iss_cls = 1'b0; iss_dst = 3'd3; #1;
    chk("R2 pending dst stall", 32'(iss_stall), 1);
    iss_dst = 3'd6; #1;
    chk("R2 other dst ok", 32'(iss_stall), 0);
    chk("R3 next free", 32'(iss_tag), 2);
    iss_valid = 1'b0; #1;
    done(4'b1101, 32'h3030_3030, 0, 32'h1010_1010, 32'h2020_2020);
    chk("R6 early done ignored", 32'(wb_grant), 4);
    step;
    chk("R8 unit3 next", 32'(wb_grant), 8);
    step;
    chk("R6 no wb for unit0", 32'(wb_grant), 0);
    done(4'b0001, 32'h3030_3030, 0, 0, 0);
    chk("R6 unit0 after done", 32'(wb_grant), 1);
    step;
    mreg[1] = 32'h1010_1010; mreg[2] = 32'h2020_2020; mreg[3] = 32'h3030_3030;

    // R11 source equals own destination
    issue(1'b0, 4'd0, 3'd3, 3'd3, 3'd3, 3'd1, "R11 self");
    chk("R11 old value a", rd_a, mreg[3]);
    chk("R11 old value b", rd_b, mreg[3]);
    step;
    done(4'b0001, mreg[3] + 1, 0, 0, 0);
    chk("R11 wb data", wb_data, mreg[3] + 1);
    step;
    mreg[3] = mreg[3] + 1;
    issue(1'b0, 4'd0, 3'd0, 3'd3, 3'd1, 3'd1, "R11 readback");
    chk("R11 new value", rd_a, mreg[3]);
    chk("R9 r1 value", rd_b, mreg[1]);
    step;
    done(4'b0001, 0, 0, 0, 0);
    step;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule